// File: doc/BRIEF.md
# Pipelined Converter Alignment and Correction Back End

This block is the digital tail of a nine-stage pipelined analog-to-digital converter. Eight redundant sub-converter stages and one final flash stage each hand over a 2-bit decision per sample. Adjacent stages run on opposite clock phases, so the decisions for one sample reach the block spread over several clocks. Stage k's code arrives ceil(k/2) clocks after the code of stage 0 for the same sample. Per-stage delay lines re-time every code so that all nine meet in one aligned bank. An overlapped adder then turns the 18 aligned bits into a 10-bit word. The redundant bit in each stage absorbs decision errors made upstream.

The corrected word goes through two output registers. The first of these applies the number-format choice (offset binary, or two's complement formed by inverting the MSB). The second drives the data pins, which float when output enable is deasserted. A small state machine holds the valid qualifier low while the pipeline warms up after reset. Its state ST_WARM counts sampling clocks. The transition "warm count reaches limit" moves it to ST_LIVE, where it stays. Only reset returns it to ST_WARM.

Top module: `adc_pipe_backend`

## Requirements
- R1: The code of stage k (k = 0..8, packed at bits 2k+1:2k of `stage_code`) for a given sample is taken from the clock that comes ceil(k/2) clocks after that sample's stage 0 code. All nine codes for that sample are combined with each other and with no other sample's codes.
- R2: The corrected value is the sum over k of code_k × 2^(8−k): stage 0 is weighted at bits 9:8, and each later stage sits one bit lower than the one before it, ending with the flash stage at bits 1:0.
- R3: Any set of stage codes that sums to a value V in 0..1023 yields V. This holds whether or not individual stages made a decision that is one step off, since the redundancy cancels it.
- R4: The result for the sample whose stage 0 code is captured on clock edge n appears on `data_out` after edge n+7. Each following sample appears one clock later.
- R5: A sum above 1023 (for example all codes equal to 3, a raw total of 1533, or a raw total of exactly 1024) is clamped to 1023.
- R6: With `fmt_twos` low the output is offset binary. With it high, bit 9 is inverted and bits 8:0 are unchanged. The format is taken from the value of `fmt_twos` at edge n+6, one clock before the word reaches the pins.
- R7: While `oe_hiz` is high, all ten `data_out` bits are high impedance, without waiting for a clock. While it is low, they drive the registered word.
- R8: After reset is released, `data_valid` is low through the first 19 rising edges, goes high on the 20th, and stays high until the next reset.
- R9: While reset is asserted, `data_out` (when enabled) is zero and `data_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_code | input | 18 | Raw 2-bit stage decisions; stage k at bits 2k+1:2k, stage 8 is the flash |
| fmt_twos | input | 1 | 0 selects offset binary, 1 selects two's complement |
| oe_hiz | input | 1 | 1 floats the data outputs, 0 drives them |
| data_out | output | 10 | Corrected, formatted and double-registered sample |
| data_valid | output | 1 | High once the warm-up period after reset has elapsed |

## Verification
The hardest situation to reach is a set of stage decisions that disagree with the ideal binary split of a value but are still correctable. Driving real sample values never produces such a set unless the stimulus creates it on purpose. The bench therefore breaks each value into stage codes itself, pushing random stages one step up or down. After each push it checks that the remainder still fits what the later stages can express, so the redundant bits are exercised. The bench also spreads each sample's codes over the staggered clocks. Any delay-line depth error therefore mixes codes of neighbouring samples, and the mixing shows in the per-clock comparison.

// File: rtl/adc_bk_pkg.sv
package adc_bk_pkg;

    // Warm-up qualifier states
    typedef enum logic {
        ST_WARM = 1'b0,
        ST_LIVE = 1'b1
    } warm_state_e;

    // Clocks between stage 0 and stage k capturing the same sample
    function automatic int stage_lag(input int k);
        return (k + 1) / 2;
    endfunction

endpackage

// File: rtl/adc_stage_align.sv
module adc_stage_align
    import adc_bk_pkg::*;
#(
    parameter int NSTAGE = 9,
    parameter int CODE_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSTAGE*CODE_W-1:0]   raw_codes,
    output logic [NSTAGE*CODE_W-1:0]   aligned
);

    localparam int LAST_LAG = stage_lag(NSTAGE - 1);

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        // Early stages wait longer so every code of a sample lands together
        localparam int DEPTH = 1 + LAST_LAG - stage_lag(k);

        logic [CODE_W-1:0] tap [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    tap[i] <= '0;
                end
            end else begin
                tap[0] <= raw_codes[k*CODE_W +: CODE_W];
                for (int i = 1; i < DEPTH; i++) begin
                    tap[i] <= tap[i-1];
                end
            end
        end

        assign aligned[k*CODE_W +: CODE_W] = tap[DEPTH-1];
    end

endmodule

// File: rtl/adc_overlap_sum.sv
module adc_overlap_sum #(
    parameter int NSTAGE = 9,
    parameter int CODE_W = 2,
    parameter int OUT_W  = NSTAGE + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSTAGE*CODE_W-1:0]   aligned,
    output logic [OUT_W-1:0]           sum_q
);

    localparam int SUM_W   = NSTAGE + CODE_W;
    localparam int MAX_OUT = (1 << OUT_W) - 1;

    logic [SUM_W-1:0] raw_sum;
    logic [OUT_W-1:0] clamped;

    // Each stage sits one bit below its predecessor
    always_comb begin
        raw_sum = '0;
        for (int k = 0; k < NSTAGE; k++) begin
            raw_sum = raw_sum
                    + (SUM_W'(aligned[k*CODE_W +: CODE_W]) << (NSTAGE - 1 - k));
        end
    end

    always_comb begin
        if (raw_sum > SUM_W'(MAX_OUT)) begin
            clamped = OUT_W'(MAX_OUT);
        end else begin
            clamped = raw_sum[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= clamped;
        end
    end

endmodule

// File: rtl/adc_out_regs.sv
module adc_out_regs #(
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] sum_q,
    input  logic             fmt_twos,
    output logic [OUT_W-1:0] first_q,
    output logic [OUT_W-1:0] final_q
);

    logic [OUT_W-1:0] formatted;

    always_comb begin
        formatted = sum_q;
        formatted[OUT_W-1] = sum_q[OUT_W-1] ^ fmt_twos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            final_q <= '0;
        end else begin
            first_q <= formatted;
            final_q <= first_q;
        end
    end

endmodule

// File: rtl/adc_warmup_fsm.sv
module adc_warmup_fsm
    import adc_bk_pkg::*;
#(
    parameter int WARMUP = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);

    localparam int CNT_W = $clog2(WARMUP + 1);

    warm_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WARM;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_WARM: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == CNT_W'(WARMUP - 1)) begin
                    state_d = ST_LIVE;
                end
            end
            ST_LIVE: begin
                cnt_d = cnt_q;
            end
            default: begin
                state_d = ST_WARM;
            end
        endcase
    end

    always_comb begin
        ready = (state_q == ST_LIVE);
    end

endmodule

// File: rtl/adc_pipe_backend.sv
module adc_pipe_backend #(
    parameter int NSTAGE = 9,
    parameter int CODE_W = 2,
    parameter int WARMUP = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSTAGE*CODE_W-1:0]  stage_code,
    input  logic                      fmt_twos,
    input  logic                      oe_hiz,
    output wire  [NSTAGE:0]           data_out,
    output logic                      data_valid
);

    localparam int OUT_W = NSTAGE + 1;
    localparam int RAW_W = NSTAGE * CODE_W;

    logic [RAW_W-1:0] aligned_codes;
    logic [OUT_W-1:0] sum_q;
    logic [OUT_W-1:0] first_q;
    logic [OUT_W-1:0] final_q;

    adc_stage_align #(
        .NSTAGE (NSTAGE),
        .CODE_W (CODE_W)
    ) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_codes (stage_code),
        .aligned   (aligned_codes)
    );

    adc_overlap_sum #(
        .NSTAGE (NSTAGE),
        .CODE_W (CODE_W),
        .OUT_W  (OUT_W)
    ) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .aligned (aligned_codes),
        .sum_q   (sum_q)
    );

    adc_out_regs #(
        .OUT_W (OUT_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .sum_q    (sum_q),
        .fmt_twos (fmt_twos),
        .first_q  (first_q),
        .final_q  (final_q)
    );

    adc_warmup_fsm #(
        .WARMUP (WARMUP)
    ) u_warm (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (data_valid)
    );

    assign data_out = oe_hiz ? {OUT_W{1'bz}} : final_q;

endmodule

// File: rtl/adc_pipe_backend_chk.sv
module adc_pipe_backend_chk #(
    parameter int NSTAGE = 9,
    parameter int CODE_W = 2,
    parameter int WARMUP = 20
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      fmt_twos,
    input logic [NSTAGE*CODE_W-1:0]  aligned_codes,
    input logic [NSTAGE:0]           sum_q,
    input logic [NSTAGE:0]           first_q,
    input logic                      data_valid
);

    localparam int OUT_W   = NSTAGE + 1;
    localparam int CNT_W   = $clog2(WARMUP + 1);
    localparam int MAX_OUT = (1 << OUT_W) - 1;

    // Rising edges since reset release, held at WARMUP
    logic [CNT_W-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != CNT_W'(WARMUP)) begin
            age <= age + 1'b1;
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> data_valid); // R8

    AST_VALID_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (age < CNT_W'(WARMUP)) |-> !data_valid); // R8

    AST_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (age == CNT_W'(WARMUP)) |-> data_valid); // R8

    AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (&aligned_codes) |=> (sum_q == OUT_W'(MAX_OUT))); // R5

    AST_FMT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= CNT_W'(2)) |-> (first_q[OUT_W-1] == $past(sum_q[OUT_W-1] ^ fmt_twos))); // R6

    AST_FMT_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= CNT_W'(2)) |-> (first_q[OUT_W-2:0] == $past(sum_q[OUT_W-2:0]))); // R6

endmodule

bind adc_pipe_backend adc_pipe_backend_chk #(
    .NSTAGE (NSTAGE),
    .CODE_W (CODE_W),
    .WARMUP (WARMUP)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fmt_twos      (fmt_twos),
    .aligned_codes (aligned_codes),
    .sum_q         (sum_q),
    .first_q       (first_q),
    .data_valid    (data_valid)
);

// File: tb/adc_pipe_backend_bench.sv
module adc_pipe_backend_bench;

    localparam int NST  = 9;
    localparam int MAXS = 512;
    localparam int LAST = 330;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] stage_code = '0;
    logic        fmt_twos = 1'b0;
    logic        oe_hiz = 1'b0;
    wire  [9:0]  dout_w;
    logic        data_valid;

    int          samp_code [MAXS][NST];
    string       samp_tag  [MAXS];
    bit          fmt_hist  [MAXS];
    bit          oe_hist   [MAXS];
    int          total = 0;
    int          fails = 0;
    bit          done = 1'b0;
    int          edge_n = 0;

    always #10 clk = ~clk;

    for (genvar i = 0; i < 10; i++) begin : g_pu
        pullup (dout_w[i]);
    end

    adc_pipe_backend u_adc_pipe_backend (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_code (stage_code),
        .fmt_twos   (fmt_twos),
        .oe_hiz     (oe_hiz),
        .data_out   (dout_w),
        .data_valid (data_valid)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_plan();
        for (int n = 0; n < MAXS; n++) begin
            for (int k = 0; k < NST; k++) samp_code[n][k] = 0;
            samp_tag[n] = "R3";
            fmt_hist[n] = 1'b0;
            oe_hist[n]  = 1'b0;
        end
    endtask

    // Split v into stage codes; with err set, random stages go one step off
    task automatic plan_value(input int n, input int v, input bit err);
        int r = v;
        for (int k = 0; k < NST - 1; k++) begin
            int w   = 1 << (8 - k);
            int cap = 3 * (w - 1);
            int c   = r / w;
            if (c > 3) c = 3;
            if (err && ($urandom % 3 == 0)) begin
                int alt = ($urandom % 2) ? c + 1 : c - 1;
                if (alt >= 0 && alt <= 3 && r - alt * w >= 0 && r - alt * w <= cap)
                    c = alt;
            end
            samp_code[n][k] = c;
            r -= c * w;
        end
        samp_code[n][NST-1] = r;
    endtask

    function automatic logic [17:0] bus_for_edge(input int e);
        logic [17:0] b = '0;
        for (int k = 0; k < NST; k++) begin
            int n = e - (k + 1) / 2;
            if (n >= 1 && n < MAXS) b[2*k +: 2] = 2'(samp_code[n][k]);
        end
        return b;
    endfunction

    function automatic int expect_data(input int e);
        int n = e - 7;
        int raw = 0;
        if (n >= 1 && n < MAXS) begin
            for (int k = 0; k < NST; k++) raw += samp_code[n][k] << (8 - k);
        end
        if (raw > 1023) raw = 1023;
        if (fmt_hist[e-1]) raw = raw ^ 512;
        return raw;
    endfunction

    function automatic bit in_range(input int e);
        return (e >= 0 && e < MAXS);
    endfunction

    task automatic drive_next();
        stage_code = bus_for_edge(edge_n + 1);
        fmt_twos   = in_range(edge_n + 1) ? fmt_hist[edge_n + 1] : 1'b0;
    endtask

    // One rising edge, then checks at the following falling edge
    task automatic run_edge();
        @(posedge clk);
        edge_n++;
        @(negedge clk);
        oe_hiz = in_range(edge_n) ? oe_hist[edge_n] : 1'b0;
        #1;
        chk(data_valid == (edge_n >= 20), "R8", "data_valid", int'(data_valid),
            int'(edge_n >= 20));
        if (oe_hiz) begin
            chk(dout_w == 10'h3FF, "R7", "floating bus", int'(dout_w), 1023);
        end else if (edge_n >= 8) begin
            chk(dout_w == 10'(expect_data(edge_n)), samp_tag[edge_n - 7], "data_out",
                int'(dout_w), expect_data(edge_n));
        end
        drive_next();
    endtask

    task automatic check_reset_state();
        oe_hiz = 1'b0;
        #1;
        chk(dout_w == 10'd0, "R9", "data_out in reset", int'(dout_w), 0);
        chk(data_valid == 1'b0, "R9", "data_valid in reset", int'(data_valid), 0);
    endtask

    initial begin
        clear_plan();
        // R3: plain binary splits, then splits with correctable stage errors (R1)
        for (int n = 1; n <= 40; n++) plan_value(n, int'($urandom % 1024), 1'b0);
        for (int n = 41; n <= 140; n++) begin
            plan_value(n, int'($urandom % 1024), 1'b1);
            samp_tag[n] = "R1 R3";
        end
        // R2: one stage at a time carries a code of 1
        for (int k = 0; k < NST; k++) begin
            samp_code[141 + k][k] = 1;
            samp_tag[141 + k] = "R2";
        end
        for (int k = 0; k < NST; k++) samp_code[150][k] = 2;
        samp_tag[150] = "R2";
        // R5: overflowing totals and the top code
        for (int n = 151; n <= 170; n++) begin
            samp_tag[n] = "R5";
            case (n % 3)
                0: for (int k = 0; k < NST; k++) samp_code[n][k] = 3;
                1: begin samp_code[n][0] = 3; samp_code[n][1] = 2; end
                default: plan_value(n, 1023, 1'b1);
            endcase
        end
        // R6: format toggles per clock
        for (int n = 171; n <= 260; n++) begin
            plan_value(n, int'($urandom % 1024), 1'b1);
            samp_tag[n] = "R6";
        end
        for (int e = 171; e <= 270; e++) fmt_hist[e] = 1'($urandom % 2);
        // R7: output enable toggling
        for (int n = 261; n <= 300; n++) begin
            plan_value(n, int'($urandom % 1024), 1'b1);
            samp_tag[n] = "R7";
        end
        for (int e = 268; e <= 308; e++) oe_hist[e] = ($urandom % 3 == 0);
        // R4: isolated samples among zeros, two's complement format
        for (int n = 301; n <= 322; n++) samp_tag[n] = "R4";
        plan_value(310, 700, 1'b1);
        plan_value(320, 1023, 1'b0);
        for (int e = 301; e <= LAST; e++) fmt_hist[e] = 1'b1;

        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        edge_n = 0;
        drive_next();
        while (edge_n < LAST) run_edge();

        // Second reset: warm-up starts over (R8, R9)
        @(negedge clk);
        rst_n = 1'b0;
        clear_plan();
        stage_code = '0;
        fmt_twos = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        edge_n = 0;
        drive_next();
        while (edge_n < 25) run_edge();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", edge_n, LAST);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule